// File: doc/BRIEF.md
# Converter Configuration Word Register and Power-Mode Decoder

This block keeps the configuration of a two-channel converter. Software or a host controller places an eight-bit configuration word on the upper bits of the channel A data port and pulses an active-low write strobe. The word is latched when the strobe goes high again. The strobe has no timing relation to the sample clock, so the latched word crosses into a free-running timebase clock domain through a toggle handshake.

In the timebase domain the word is split into its fields: power-down, channel enable, interleaved input, external reference and a four-bit gain trim code for channel A. The power-down and enable bits decode to one of three power modes. The gain code is also given as a signed trim in 0.05 dB steps.

A wake-up timer runs whenever the mode returns to normal operation from standby or power-down. Each source state has its own cycle count. The ready flag stays low until that count has elapsed. After power-on reset the register holds a fixed default: normal operation, internal reference, non-interleaved input and 0 dB trim.

Top module: `ctrl_word_decoder`

## Requirements
- R1: After reset the block reports normal mode (`pwr_mode` = 2'b00), internal reference (`ext_ref` = 0), non-interleaved input (`ilv_en` = 0), `gain_code` = 4'b1000, `gain_trim` = 0 and `ready` = 1.
- R2: The captured word maps port bits as follows: bit 9 = power-down, bit 8 = enable, bit 7 = interleave (`ilv_en`), bit 6 = reference select (`ext_ref`, 1 = external) and bits 5:2 = `gain_code`. Bits 1:0 are ignored.
- R3: The word is captured only on a rising edge of `wr_n`. Changes on `port_a` without such an edge have no effect. A captured word appears on the outputs after the third rising `clk` edge that follows the strobe's rising edge.
- R4: `pwr_mode` is 2'b10 (power-down) when bit 9 is 1, whatever the other bits are. It is 2'b01 (standby) when bits 9 and 8 are both 0. It is 2'b00 (normal) when bit 9 is 0 and bit 8 is 1. The value 2'b11 never occurs.
- R5: `gain_trim` is a signed five-bit value equal to 8 minus `gain_code`. Code 0 gives +8, code 8 gives 0 and code 15 gives -7.
- R6: `ready` is 0 whenever `pwr_mode` is not normal.
- R7: On a move from standby to normal, `ready` rises at the (SB_CYC+1)-th rising `clk` edge after the mode output changes, and not before.
- R8: On a move from power-down to normal, `ready` rises at the (PD_CYC+1)-th rising `clk` edge after the mode output changes, and not before.
- R9: A new word that keeps normal mode while `ready` is 1 does not drop `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous to `clk` |
| port_a | input | 10 | Channel A data port; bits 9:2 carry the configuration word |
| wr_n | input | 1 | Active-low write strobe; the word is latched on its rising edge |
| pwr_mode | output | 2 | 00 normal, 01 standby, 10 power-down |
| ilv_en | output | 1 | Interleaved input enabled |
| ext_ref | output | 1 | External reference selected |
| gain_code | output | 4 | Raw gain trim code |
| gain_trim | output | 5 | Signed trim in 0.05 dB steps (8 − code) |
| ready | output | 1 | Output valid; low during wake-up and outside normal mode |

## Verification
Directed words cover the reset default, the extreme and middle gain codes, and power-down with the enable bit both set and clear. Together these distinguish a wrong field position, a sign error in the trim and a wrong mode priority. The wake-up paths from standby and from power-down are sampled one cycle before and exactly at the expected rise of `ready`, which exposes off-by-one counts and a swapped count choice. A burst of seeded random words, each followed by a full settling wait, exercises every mode transition pair. A port change with no strobe confirms that nothing is captured without a rising edge.

// File: rtl/cwd_pkg.sv
// Package: shared types and reset default of the configuration word.
package cwd_pkg;
    // Power modes; the encoding is visible on the top-level port.
    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_IDLE = 2'b01,
        PM_OFF  = 2'b10
    } pwr_mode_e;

    // Configuration word; field order follows port bits 9 down to 2.
    typedef struct packed {
        logic       off;
        logic       en;
        logic       ilv;
        logic       ext;
        logic [3:0] gain;
    } cfg_word_t;

    localparam int CFG_W = $bits(cfg_word_t);
    localparam cfg_word_t CFG_DEFAULT = '{off: 1'b0, en: 1'b1, ilv: 1'b0,
                                          ext: 1'b0, gain: 4'b1000};
endpackage

// File: rtl/cwd_capture.sv
// Strobe-domain capture: latches the word and flips a toggle on each
// rising edge of the write strobe.
// Assumes: the strobe is high and low for at least 5 ns each. The toggle is
// reset asynchronously because the strobe may not pulse during reset.
module cwd_capture
    import cwd_pkg::*;
(
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [CFG_W-1:0]  word_in,
    output cfg_word_t         word_hold,
    output logic              wr_tgl
);
    // Data hold register; only read after the toggle has been synchronized.
    always_ff @(posedge wr_n) begin
        word_hold <= cfg_word_t'(word_in);
    end

    // Write toggle, one flip per strobe rising edge.
    always_ff @(posedge wr_n or negedge rst_n) begin
        if (!rst_n) wr_tgl <= 1'b0;
        else        wr_tgl <= ~wr_tgl;
    end
endmodule

// File: rtl/cwd_cdc.sv
// Timebase-domain transfer: synchronizes the write toggle through SYNC_STAGES
// flops and loads the held word when the toggle changes.
// Assumes: writes are spaced by at least SYNC_STAGES+2 timebase cycles, so the
// held word is stable when it is loaded.
module cwd_cdc
    import cwd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_tgl,
    input  cfg_word_t word_hold,
    output cfg_word_t word_q
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   seen_q;
    logic                   load;

    // Toggle synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], wr_tgl};
    end

    // Last toggle value acted on.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= sync_q[SYNC_STAGES-1];
    end

    assign load = sync_q[SYNC_STAGES-1] ^ seen_q;

    // Configuration register with the power-on default.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= CFG_DEFAULT;
        else if (load) word_q <= word_hold;
    end
endmodule

// File: rtl/cwd_decode.sv
// Field decoder: power mode by priority (power-down over enable) and the
// signed gain trim.
module cwd_decode
    import cwd_pkg::*;
#(
    parameter int GAIN_W = 4
) (
    input  cfg_word_t                word_q,
    output pwr_mode_e                mode,
    output logic signed [GAIN_W:0]   trim
);
    localparam logic signed [GAIN_W:0] MID = (GAIN_W+1)'(1 << (GAIN_W-1));

    // Mode priority: power-down first, then enable.
    always_comb begin
        if (word_q.off)     mode = PM_OFF;
        else if (!word_q.en) mode = PM_IDLE;
        else                mode = PM_RUN;
    end

    // Trim steps: midpoint minus the code.
    always_comb begin
        trim = MID - $signed({1'b0, word_q.gain});
    end
endmodule

// File: rtl/cwd_wake.sv
// Wake-up timer: on a move into normal mode it loads the count for the
// state being left and holds ready low until the count has run out.
// Assumes: PD_CYC >= SB_CYC >= 1.
module cwd_wake
    import cwd_pkg::*;
#(
    parameter int SB_CYC = 150,
    parameter int PD_CYC = 25000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pwr_mode_e mode,
    output logic      ready
);
    localparam int CW = $clog2(PD_CYC + 1);

    pwr_mode_e     prev_q;
    logic [CW-1:0] cnt_q;
    logic          rdy_q;

    // Mode seen on the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= PM_RUN;
        else        prev_q <= mode;
    end

    // Count load, countdown and ready update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rdy_q <= 1'b1;
        end else if (mode != PM_RUN) begin
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else if (prev_q != PM_RUN) begin
            cnt_q <= (prev_q == PM_OFF) ? CW'(PD_CYC) : CW'(SB_CYC);
            rdy_q <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) rdy_q <= 1'b1;
        end
    end

    assign ready = rdy_q && (mode == PM_RUN);
endmodule

// File: rtl/ctrl_word_decoder.sv
// Top: configuration word register, power-mode decoder and wake-up timer.
// Assumes: rst_n is held low for at least SYNC_STAGES+1 clk cycles and
// writes are spaced by at least SYNC_STAGES+2 clk cycles.
module ctrl_word_decoder
    import cwd_pkg::*;
#(
    parameter int SB_CYC      = 150,
    parameter int PD_CYC      = 25000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        port_a,
    input  logic              wr_n,
    output logic [1:0]        pwr_mode,
    output logic              ilv_en,
    output logic              ext_ref,
    output logic [3:0]        gain_code,
    output logic signed [4:0] gain_trim,
    output logic              ready
);
    cfg_word_t word_hold;
    cfg_word_t word_q;
    logic      wr_tgl;
    pwr_mode_e mode;

    cwd_capture u_cap (
        .rst_n     (rst_n),
        .wr_n      (wr_n),
        .word_in   (port_a[9:10-CFG_W]),
        .word_hold (word_hold),
        .wr_tgl    (wr_tgl)
    );

    cwd_cdc #(.SYNC_STAGES(SYNC_STAGES)) u_cdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_tgl    (wr_tgl),
        .word_hold (word_hold),
        .word_q    (word_q)
    );

    cwd_decode #(.GAIN_W(4)) u_dec (
        .word_q (word_q),
        .mode   (mode),
        .trim   (gain_trim)
    );

    cwd_wake #(.SB_CYC(SB_CYC), .PD_CYC(PD_CYC)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .ready (ready)
    );

    assign pwr_mode  = mode;
    assign ilv_en    = word_q.ilv;
    assign ext_ref   = word_q.ext;
    assign gain_code = word_q.gain;
endmodule

// File: rtl/ctrl_word_decoder_chk.sv
// Checker: temporal properties of the configuration outputs, bound to the top.
module ctrl_word_decoder_chk (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        pwr_mode,
    input logic [3:0]        gain_code,
    input logic signed [4:0] gain_trim,
    input logic              ready
);
    AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwr_mode == 2'b00 && gain_code == 4'b1000 && ready)); // R1

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode != 2'b11); // R4

    AST_TRIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_trim >= -5'sd7) && (gain_trim <= 5'sd8)); // R5

    AST_READY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode != 2'b00) |-> !ready); // R6

    AST_WAKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_mode) != 2'b00 && pwr_mode == 2'b00) |-> !ready); // R7

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && pwr_mode == 2'b00) |=> (ready || pwr_mode != 2'b00)); // R9
endmodule

bind ctrl_word_decoder ctrl_word_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_mode  (pwr_mode),
    .gain_code (gain_code),
    .gain_trim (gain_trim),
    .ready     (ready)
);

// File: tb/ctrl_word_decoder_test.sv
// Bench: directed corner cases plus seeded random words, checked against
// bench-side models of the field map, mode decode and wake timing.
module ctrl_word_decoder_test;
    localparam int SB = 6;
    localparam int PD = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [9:0]        port_a = '0;
    logic              wr_n = 1'b1;
    logic [1:0]        pwr_mode;
    logic              ilv_en, ext_ref, ready;
    logic [3:0]        gain_code;
    logic signed [4:0] gain_trim;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    ctrl_word_decoder #(.SB_CYC(SB), .PD_CYC(PD)) uut (
        .clk(clk), .rst_n(rst_n), .port_a(port_a), .wr_n(wr_n),
        .pwr_mode(pwr_mode), .ilv_en(ilv_en), .ext_ref(ext_ref),
        .gain_code(gain_code), .gain_trim(gain_trim), .ready(ready)
    );

    always #10 clk = ~clk;

    function automatic int exp_mode(logic [9:0] w);
        if (w[9])      return 2;
        else if (!w[8]) return 1;
        else           return 0;
    endfunction

    function automatic int exp_trim(logic [9:0] w);
        return 8 - int'(w[5:2]);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Writes one word and returns at the falling edge after the third rising edge.
    task automatic write_word(logic [9:0] w);
        @(negedge clk);
        port_a = w;
        wr_n   = 1'b0;
        #5 wr_n = 1'b1;
        #2 port_a = 10'($urandom);
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_fields(string req, logic [9:0] w);
        chk({req, " mode"}, int'(pwr_mode), exp_mode(w));
        chk({req, " ilv"}, int'(ilv_en), int'(w[7]));
        chk({req, " ext"}, int'(ext_ref), int'(w[6]));
        chk({req, " code"}, int'(gain_code), int'(w[5:2]));
        chk({req, " trim"}, int'(gain_trim), exp_trim(w));
    endtask

    task automatic settle();
        repeat (PD + 3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [9:0] w;
        logic [9:0] prev;
        void'($urandom(32'h1c3b));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset defaults
        chk("R1 mode", int'(pwr_mode), 0);
        chk("R1 ext", int'(ext_ref), 0);
        chk("R1 ilv", int'(ilv_en), 0);
        chk("R1 code", int'(gain_code), 8);
        chk("R1 trim", int'(gain_trim), 0);
        chk("R1 ready", int'(ready), 1);

        // R3 port activity without a strobe edge
        port_a = 10'b1011_1111_11;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R3 no strobe mode", int'(pwr_mode), 0);
        chk("R3 no strobe code", int'(gain_code), 8);

        // R2 R5 gain extremes, bits 1:0 ignored, normal kept (R9)
        w = 10'b0111_0000_11;
        write_word(w);
        check_fields("R2", w);
        chk("R5 code0", int'(gain_trim), 8);
        chk("R9 ready", int'(ready), 1);
        w = 10'b0100_1111_00;
        write_word(w);
        check_fields("R5", w);
        chk("R5 code15", int'(gain_trim), -7);

        // R3 timing: no change after the second rising edge
        @(negedge clk);
        port_a = 10'b0001_1000_00;
        wr_n = 1'b0;
        #5 wr_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R3 early", int'(gain_code), 15);
        @(posedge clk);
        @(negedge clk);
        chk("R3 third edge mode", int'(pwr_mode), 1);
        chk("R6 standby ready", int'(ready), 0);

        // R7 wake from standby
        w = 10'b0100_1000_00;
        write_word(w);
        chk("R7 start", int'(ready), 0);
        repeat (SB) @(posedge clk);
        @(negedge clk);
        chk("R7 one early", int'(ready), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 rise", int'(ready), 1);

        // R4 power-down regardless of enable, then R8 wake
        w = 10'b1000_0101_00;
        write_word(w);
        check_fields("R4 off en0", w);
        chk("R6 off ready", int'(ready), 0);
        w = 10'b1111_1010_00;
        write_word(w);
        check_fields("R4 off en1", w);
        w = 10'b0100_1000_00;
        write_word(w);
        repeat (PD) @(posedge clk);
        @(negedge clk);
        chk("R8 one early", int'(ready), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 rise", int'(ready), 1);

        // Random words with full settling between them
        prev = w;
        for (int i = 0; i < 40; i++) begin
            w = 10'($urandom);
            write_word(w);
            check_fields("R4 random", w);
            chk("R9 R6 random now", int'(ready),
                (exp_mode(w) == 0 && exp_mode(prev) == 0) ? 1 : 0);
            settle();
            chk("R7 R8 random settled", int'(ready), exp_mode(w) == 0 ? 1 : 0);
            prev = w;
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule